// File: doc/BRIEF.md
# Coalescing Host Interrupt Controller

This block collects single-cycle event pulses from internal sources into a host-visible interrupt status word. The host clears flags by writing ones, and selects which flags may reach the interrupt line through an enable word. Direct-memory-access channel events are held in a separate second-level status word. Receive flags, transmit flags and the error flag of that word are each folded into one summary bit of the main status word.

A programmable coalescing window holds back the host line so that several interrupts can gather before the host is disturbed. The window is counted in units of 32 microsecond ticks. A high-priority receive event skips the window and raises the line at once. The host reaches all state through a plain address, write data, write strobe and read data port.

Top module: `hostirq_coalescer`

## Requirements
- R1: After reset the coalescing setting, main status, enable word and DMA status all read as 0, and `irq_o` is 0.
- R2: The register port decodes byte offsets 0x004 (coalescing units, low `COAL_W` bits, 8 by default), 0x008 (main status), 0x00C (enable word) and 0x010 (DMA status). Any other offset reads 0. The enable word keeps only the implemented main bits, so writing all ones reads back 0xBE0000CB.
- R3: A pulse on `main_evt_i` sets the matching main status bit for positions 28, 26, 25, 7, 6, 3, 1 and 0. A pulse at any other position leaves the main status unchanged.
- R4: Writing a 1 to a bit position of the main or DMA status clears that flag. Writing a 0 leaves it unchanged.
- R5: An event pulse in the same cycle as a host write of 1 to that bit leaves the bit set.
- R6: A pulse on `dma_evt_i` sets the matching DMA status bit for positions 31 (error), 30 (high-priority receive), 18, 17 and 16 (receive channels), and 6, 1 and 0 (transmit channels). A pulse at any other position is ignored.
- R7: Main bit 31 reads 1 while any of DMA bits 30, 18, 17 or 16 is set. Main bit 27 reads 1 while any of DMA bits 6, 1 or 0 is set. Main bit 29 mirrors DMA bit 31. A write of 1 to these main bits has no effect; they clear when the DMA flags clear.
- R8: `irq_o` is 0 whenever the bitwise AND of main status and enable word is zero.
- R9: With a coalescing setting of 0, `irq_o` rises in the first cycle in which an enabled flag reads set.
- R10: With a coalescing setting N > 0, `irq_o` stays 0 until 32*N `us_tick_i` pulses have been seen after the first enabled flag became pending, and rises on the last of them.
- R11: Once the host has cleared every enabled pending flag, the window restarts, and the next event again waits the full 32*N ticks.
- R12: While DMA bit 30 is set and enable bit 31 is set, `irq_o` is 1 regardless of the coalescing window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| main_evt_i | input | 32 | Main event pulses, one bit per status position |
| dma_evt_i | input | 32 | DMA event pulses, one bit per DMA status position |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| irq_o | output | 1 | Level host interrupt |

## Verification
Two things can happen to a status bit in one cycle: a source can pulse it and the host can write 1 to clear it. The bench drives a main event and a clearing write to the same bit in the same cycle. In that cycle it also clears a second, already set bit. It then reads the status back and expects the first bit still set and the second bit cleared. Coalescing expiry can also coincide with a high-priority receive event. The bench sets a long window and pulses DMA bit 30, then checks that the line rises at once rather than after the window.

// File: rtl/hic_pkg.sv
package hic_pkg;
  localparam int unsigned REG_AW = 12;
  localparam logic [REG_AW-1:0] OFF_COAL = 12'h004;
  localparam logic [REG_AW-1:0] OFF_MAIN = 12'h008;
  localparam logic [REG_AW-1:0] OFF_MASK = 12'h00C;
  localparam logic [REG_AW-1:0] OFF_DMA  = 12'h010;

  // main bits fed directly by sources
  localparam logic [31:0] MAIN_SRC_BITS = 32'h1600_00CB;
  // main bits that summarise the DMA word (31 rx, 29 err, 27 tx)
  localparam logic [31:0] MAIN_FOLD_BITS = 32'hA800_0000;
  localparam logic [31:0] MAIN_ALL_BITS = MAIN_SRC_BITS | MAIN_FOLD_BITS;

  localparam logic [31:0] DMA_RX_BITS  = 32'h4007_0000;
  localparam logic [31:0] DMA_TX_BITS  = 32'h0000_0043;
  localparam logic [31:0] DMA_ERR_BITS = 32'h8000_0000;
  localparam logic [31:0] DMA_ALL_BITS = DMA_RX_BITS | DMA_TX_BITS | DMA_ERR_BITS;
  localparam int unsigned DMA_HIPRI_POS = 30;

  function automatic logic [31:0] fold_dma(input logic [31:0] d);
    logic [31:0] r;
    r     = '0;
    r[31] = |(d & DMA_RX_BITS);
    r[29] = |(d & DMA_ERR_BITS);
    r[27] = |(d & DMA_TX_BITS);
    return r;
  endfunction

  function automatic logic window_done(input logic [8:0] units_seen,
                                       input logic [8:0] units_set);
    return units_seen >= units_set;
  endfunction
endpackage

// File: rtl/hic_w1c_reg.sv
module hic_w1c_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] set_eff;

  assign set_eff = set_i & VALID;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= ((stat_q & ~clr_i) | set_eff) & VALID;
  end

  assign stat_o = stat_q;

  AST_W1C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((stat_q ^ $past(stat_q)) & ~$past(clr_i) & ~$past(set_i)) == '0)); // R4
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_i) & VALID & ~stat_q) == '0)); // R5
endmodule

// File: rtl/hic_coal_timer.sv
module hic_coal_timer #(
  parameter int unsigned COAL_W      = 8,
  parameter int unsigned US_PER_UNIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_i,
  input  logic              tick_i,
  input  logic [COAL_W-1:0] coal_i,
  output logic              expired_o
);
  import hic_pkg::*;
  localparam int unsigned SUB_W = $clog2(US_PER_UNIT);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(US_PER_UNIT - 1);

  logic [SUB_W-1:0]  sub_q;
  logic [COAL_W-1:0] unit_q;
  logic              expired_q;
  logic              unit_wrap;
  logic [8:0]        units_next;

  assign unit_wrap  = tick_i && (sub_q == SUB_LAST);
  assign units_next = 9'(unit_q) + 9'd1;

  always_ff @(posedge clk) begin
    if (!rst_n || !pend_i) begin
      sub_q     <= '0;
      unit_q    <= '0;
      expired_q <= 1'b0;
    end else if (tick_i && !expired_q) begin
      if (unit_wrap) begin
        sub_q  <= '0;
        unit_q <= unit_q + 1'b1;
        if (window_done(units_next, 9'(coal_i))) expired_q <= 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign expired_o = expired_q;

  AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_q) |-> $past(tick_i)); // R10
  AST_EXPIRE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    expired_q |-> $past(pend_i)); // R11
endmodule

// File: rtl/hostirq_coalescer.sv
module hostirq_coalescer #(
  parameter int unsigned COAL_W      = 8,
  parameter int unsigned US_PER_UNIT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  input  logic        reg_we_i,
  output logic [31:0] reg_rdata_o,
  input  logic [31:0] main_evt_i,
  input  logic [31:0] dma_evt_i,
  input  logic        us_tick_i,
  output logic        irq_o
);
  import hic_pkg::*;

  logic [COAL_W-1:0] coal_q;
  logic [31:0]       mask_q;
  logic [31:0]       main_raw, dma_stat, main_view;
  logic [31:0]       main_clr, dma_clr;
  logic              pending, hipri_hit, coal_zero, window_expired;

  assign main_clr = (reg_we_i && reg_addr_i == OFF_MAIN) ? reg_wdata_i : '0;
  assign dma_clr  = (reg_we_i && reg_addr_i == OFF_DMA)  ? reg_wdata_i : '0;

  hic_w1c_reg #(.W(32), .VALID(MAIN_SRC_BITS)) u_main_stat (
    .clk(clk), .rst_n(rst_n), .set_i(main_evt_i), .clr_i(main_clr), .stat_o(main_raw));

  hic_w1c_reg #(.W(32), .VALID(DMA_ALL_BITS)) u_dma_stat (
    .clk(clk), .rst_n(rst_n), .set_i(dma_evt_i), .clr_i(dma_clr), .stat_o(dma_stat));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coal_q <= '0;
      mask_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == OFF_COAL) coal_q <= reg_wdata_i[COAL_W-1:0];
      if (reg_addr_i == OFF_MASK) mask_q <= reg_wdata_i & MAIN_ALL_BITS;
    end
  end

  assign main_view = main_raw | fold_dma(dma_stat);
  assign pending   = |(main_view & mask_q);
  assign hipri_hit = dma_stat[DMA_HIPRI_POS] && mask_q[31];
  assign coal_zero = (coal_q == '0);

  hic_coal_timer #(.COAL_W(COAL_W), .US_PER_UNIT(US_PER_UNIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .pend_i(pending), .tick_i(us_tick_i),
    .coal_i(coal_q), .expired_o(window_expired));

  assign irq_o = pending && (coal_zero || window_expired || hipri_hit);

  always_comb begin
    case (reg_addr_i)
      OFF_COAL: reg_rdata_o = 32'(coal_q);
      OFF_MAIN: reg_rdata_o = main_view;
      OFF_MASK: reg_rdata_o = mask_q;
      OFF_DMA:  reg_rdata_o = dma_stat;
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((main_view & mask_q) != '0)); // R8
  AST_HIPRI_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_stat[30] && mask_q[31]) |-> irq_o); // R12
  AST_FOLD_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_stat[16] || dma_stat[30]) |-> main_view[31]); // R7
endmodule

// File: tb/hostirq_coalescer_tb_top.sv
module hostirq_coalescer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [31:0] mevt = '0;
  logic [31:0] devt = '0;
  logic        tick = 1'b0;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hostirq_coalescer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_rdata_o(rdata), .main_evt_i(mevt), .dma_evt_i(devt),
    .us_tick_i(tick), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [31:0] m, input logic [31:0] dm);
    @(negedge clk); mevt = m; devt = dm;
    @(negedge clk); mevt = '0; devt = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  function automatic logic [31:0] exp_main_src(input int b);
    case (b)
      0, 1, 3, 6, 7, 25, 26, 28: return 32'd1 << b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_dma(input int b);
    case (b)
      0, 1, 6, 16, 17, 18, 30, 31: return 32'd1 << b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_fold(input int b);
    if (b == 16 || b == 17 || b == 18 || b == 30) return 32'h8000_0000;
    if (b == 0 || b == 1 || b == 6) return 32'h0800_0000;
    if (b == 31) return 32'h2000_0000;
    return 32'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(12'h004, v); chk("R1 coal", v, 0);
    rd(12'h008, v); chk("R1 main", v, 0);
    rd(12'h00C, v); chk("R1 mask", v, 0);
    rd(12'h010, v); chk("R1 dma", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 decode
    wr(12'h00C, 32'hFFFF_FFFF); rd(12'h00C, v); chk("R2 mask readback", v, 32'hBE00_00CB);
    wr(12'h004, 32'h0000_01A5); rd(12'h004, v); chk("R2 coal width", v, 32'h0000_00A5);
    rd(12'h020, v); chk("R2 unmapped", v, 0);
    wr(12'h00C, 0); wr(12'h004, 0);

    // R3 sweep of main event positions
    for (int b = 0; b < 32; b++) begin
      wr(12'h008, 32'hFFFF_FFFF);
      pulse(32'd1 << b, 0);
      rd(12'h008, v); chk($sformatf("R3 main bit %0d", b), v, exp_main_src(b));
    end
    wr(12'h008, 32'hFFFF_FFFF);

    // R4 W1C: 0 leaves, 1 clears
    pulse(32'h1000_0081, 0);
    wr(12'h008, 32'h0000_0000); rd(12'h008, v); chk("R4 write zero", v, 32'h1000_0081);
    wr(12'h008, 32'h0000_0080); rd(12'h008, v); chk("R4 write one", v, 32'h1000_0001);

    // R5 event and clear together: bit 0 re-fires while clearing 0 and 28
    @(negedge clk); addr = 12'h008; wdata = 32'h1000_0001; we = 1'b1; mevt = 32'h1;
    @(negedge clk); we = 1'b0; wdata = '0; mevt = '0;
    rd(12'h008, v); chk("R5 event wins", v, 32'h0000_0001);
    wr(12'h008, 32'hFFFF_FFFF);

    // R6/R7 sweep of DMA positions with fold
    for (int b = 0; b < 32; b++) begin
      wr(12'h010, 32'hFFFF_FFFF);
      pulse(0, 32'd1 << b);
      rd(12'h010, v); chk($sformatf("R6 dma bit %0d", b), v, exp_dma(b));
      rd(12'h008, v); chk($sformatf("R7 fold bit %0d", b), v, exp_fold(b));
    end
    wr(12'h010, 32'hFFFF_FFFF);

    // R7 fold bits not clearable in main
    pulse(0, 32'h0001_0000);
    wr(12'h008, 32'h8000_0000); rd(12'h008, v); chk("R7 main31 sticky", v, 32'h8000_0000);
    wr(12'h010, 32'h0001_0000); rd(12'h008, v); chk("R7 clear via dma", v, 0);

    // R8 masked pending gives no irq
    wr(12'h004, 0); wr(12'h00C, 32'h0000_0002);
    pulse(32'h1, 0); chk("R8 masked", 32'(irq), 0);
    wr(12'h008, 32'hFFFF_FFFF);

    // R9 zero coalescing: immediate
    wr(12'h00C, 32'h0000_0001);
    @(negedge clk); mevt = 32'h1;
    @(negedge clk); mevt = '0;
    chk("R9 immediate", 32'(irq), 1);
    wr(12'h008, 32'h1); chk("R8 ack drops irq", 32'(irq), 0);

    // R10 window lengths 1..3 units
    for (int n = 1; n <= 3; n++) begin
      wr(12'h004, 32'(n));
      pulse(32'h1, 0);
      chk($sformatf("R10 n=%0d start", n), 32'(irq), 0);
      ticks(32 * n - 1);
      chk($sformatf("R10 n=%0d one short", n), 32'(irq), 0);
      ticks(1);
      chk($sformatf("R10 n=%0d expiry", n), 32'(irq), 1);
      // R11 ack all then re-fire: window restarts
      wr(12'h008, 32'hFFFF_FFFF);
      chk($sformatf("R11 n=%0d ack", n), 32'(irq), 0);
      pulse(32'h1, 0); ticks(1);
      chk($sformatf("R11 n=%0d restart", n), 32'(irq), 0);
      wr(12'h008, 32'hFFFF_FFFF);
      ticks(1);
    end

    // R12 high-priority bypass vs ordinary rx under long window
    wr(12'h004, 32'd200); wr(12'h00C, 32'h8000_0000);
    pulse(0, 32'h0002_0000); chk("R12 ordinary rx waits", 32'(irq), 0);
    pulse(0, 32'h4000_0000); chk("R12 hipri immediate", 32'(irq), 1);
    wr(12'h010, 32'h4000_0000); chk("R12 hipri cleared", 32'(irq), 0);
    wr(12'h010, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule